// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge Interrupts

This block gives software control of a bank of general-purpose lines through a small register bus. The bus has an address, a write enable, write data and read data. Each line can act as an input or an output. Software reads the synchronised pad level. Any line can also latch an interrupt event on a rising transition, a falling transition, or both. Pending events are collected in one status word, and a single interrupt output is raised for events that software has unmasked.

Every control field (direction, output value, rising enable, falling enable, interrupt mask) changes only through a pair of strobe addresses. A write to the set address turns on the bits written as 1. A write to the clear address turns them off. Bits written as 0 keep their old value. Because of this, two agents that own different lines never need a read-modify-write sequence. The status word is cleared by writing back the bits that were read. Pad inputs pass through a two-stage synchroniser before they reach the level register or the edge detectors.

Address map (byte addresses, 32-bit words):
- Read-only views: 0x00 level, 0x04 direction, 0x10 output value, 0x1C rising enable, 0x28 falling enable, 0x34 status, 0x38 mask.
- Set strobes: 0x08 direction, 0x14 output, 0x20 rising enable, 0x2C falling enable, 0x3C mask.
- Clear strobes: 0x0C direction, 0x18 output, 0x24 rising enable, 0x30 falling enable, 0x40 mask.

Top module: `gpio_bank`

## Requirements
- R1: After reset every line is an input (pad_oe all 0), pad_out is all 0, both edge enables and the mask are all 0, status reads 0 and irq is low.
- R2: A write to a set address (0x08, 0x14, 0x20, 0x2C, 0x3C) makes each field bit written as 1 equal to 1 from the next clock onward. Bits written as 0 keep their value.
- R3: A write to a clear address (0x0C, 0x18, 0x24, 0x30, 0x40) makes each field bit written as 1 equal to 0 from the next clock onward. Bits written as 0 keep their value.
- R4: pad_oe equals the direction field (1 = output) and pad_out equals the output-value field, bit for bit.
- R5: A read of 0x00 returns pad_in as seen through two clock stages. A pad change made between two edges is still unseen after one rising edge and is visible after the second.
- R6: With the rising enable set for a line, a 0-to-1 transition of its synchronised level sets its status bit (read at 0x34, bit n = line n). A 1-to-0 transition does not set it unless the falling enable is set.
- R7: With the falling enable set for a line, a 1-to-0 transition of its synchronised level sets its status bit.
- R8: With both enables set, a line's status bit is set by either transition direction.
- R9: A transition on a line whose matching enable is 0 leaves the status bit at 0.
- R10: A status bit stays set until a write to 0x34 has a 1 in that bit position. Such a write clears exactly the bits written as 1.
- R11: If a status-clear write and a new enabled transition on the same line occur in the same cycle, the status bit stays set.
- R12: irq is high exactly when some line has both its status bit and its mask bit set. Masking a line does not clear its status bit.
- R13: Reads of set and clear addresses, and of unmapped addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value per line |
| pad_oe | output | 32 | Output enable per line (1 = drive) |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupted control field shows up on pad_oe or pad_out on the clock after the strobe write, or in the read view of the field. A fault in the edge path shows up three clocks after a pad change: the status bit fails to appear, appears on a disabled line, or does not survive a colliding clear. A wrong mask or status bit is visible on irq in the same cycle, without any further latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_AW      = 8;
    localparam int NUM_FIELDS   = 5;

    typedef enum logic [2:0] {
        FLD_DIR  = 3'd0,
        FLD_OUT  = 3'd1,
        FLD_RISE = 3'd2,
        FLD_FALL = 3'd3,
        FLD_MASK = 3'd4
    } field_e;

    localparam logic [GPIO_AW-1:0] A_LEVEL    = 8'h00;
    localparam logic [GPIO_AW-1:0] A_DIR      = 8'h04;
    localparam logic [GPIO_AW-1:0] A_OUT      = 8'h10;
    localparam logic [GPIO_AW-1:0] A_RISE     = 8'h1C;
    localparam logic [GPIO_AW-1:0] A_FALL     = 8'h28;
    localparam logic [GPIO_AW-1:0] A_STATUS   = 8'h34;
    localparam logic [GPIO_AW-1:0] A_MASK     = 8'h38;

    // Strobe address of field f: set when clr==0, clear when clr==1.
    function automatic logic [GPIO_AW-1:0] strobe_addr(input int f, input bit clr);
        logic [GPIO_AW-1:0] a;
        case (f)
            0:       a = 8'h08;
            1:       a = 8'h14;
            2:       a = 8'h20;
            3:       a = 8'h2C;
            default: a = 8'h3C;
        endcase
        return clr ? a + 8'h04 : a;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_field.sv
module gpio_ctrl_field #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_hit,
    input  logic             clr_hit,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] value
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
    } field_t;

    field_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_hit) begin
            s_d.val = s_q.val | bits;
        end else if (clr_hit) begin
            s_d.val = s_q.val & ~bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value = s_q.val;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic             clr_hit,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] status
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] status;
    } edge_state_t;

    edge_state_t s_d, s_q;
    logic [WIDTH-1:0] up_ev, down_ev, drop;

    always_comb begin
        up_ev    = level & ~s_q.prev & rise_en;
        down_ev  = ~level & s_q.prev & fall_en;
        drop     = clr_hit ? clr_bits : '0;
        s_d.prev   = level;
        // A fresh event outranks a clear in the same cycle.
        s_d.status = (s_q.status & ~drop) | up_ev | down_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.status;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GPIO_AW-1:0]   bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [LINES-1:0]     pad_in,
    output logic [LINES-1:0]     pad_out,
    output logic [LINES-1:0]     pad_oe,
    output logic                 irq
);
    localparam int DW = 32;

    logic [LINES-1:0] field_w [NUM_FIELDS];
    logic [LINES-1:0] level_w;
    logic [LINES-1:0] status_w;
    logic [LINES-1:0] dir_w, out_w, rise_w, fall_w, mask_w;
    logic [LINES-1:0] wbits;
    logic             status_clr;

    assign wbits      = bus_wdata[LINES-1:0];
    assign status_clr = bus_we && (bus_addr == A_STATUS);

    gpio_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_w)
    );

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic set_hit, clr_hit;
        assign set_hit = bus_we && (bus_addr == strobe_addr(f, 1'b0));
        assign clr_hit = bus_we && (bus_addr == strobe_addr(f, 1'b1));

        gpio_ctrl_field #(
            .WIDTH (LINES)
        ) u_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_hit (set_hit),
            .clr_hit (clr_hit),
            .bits    (wbits),
            .value   (field_w[f])
        );
    end

    assign dir_w  = field_w[FLD_DIR];
    assign out_w  = field_w[FLD_OUT];
    assign rise_w = field_w[FLD_RISE];
    assign fall_w = field_w[FLD_FALL];
    assign mask_w = field_w[FLD_MASK];

    gpio_edge_status #(
        .WIDTH (LINES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_w),
        .rise_en  (rise_w),
        .fall_en  (fall_w),
        .clr_hit  (status_clr),
        .clr_bits (wbits),
        .status   (status_w)
    );

    always_comb begin
        logic [LINES-1:0] sel;
        case (bus_addr)
            A_LEVEL:  sel = level_w;
            A_DIR:    sel = dir_w;
            A_OUT:    sel = out_w;
            A_RISE:   sel = rise_w;
            A_FALL:   sel = fall_w;
            A_STATUS: sel = status_w;
            A_MASK:   sel = mask_w;
            default:  sel = '0;
        endcase
        bus_rdata = DW'(sel);
    end

    assign pad_oe  = dir_w;
    assign pad_out = out_w;
    assign irq     = |(status_w & mask_w);
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_pkg::*;
#(
    parameter int LINES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [GPIO_AW-1:0] bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [LINES-1:0]   pad_oe,
    input logic [LINES-1:0]   status,
    input logic [LINES-1:0]   rise_en,
    input logic [LINES-1:0]   fall_en,
    input logic               irq
);
    logic [LINES-1:0] wb;
    assign wb = bus_wdata[LINES-1:0];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0 && pad_oe == '0 && !irq));

    assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == strobe_addr(0, 1'b0)) |=> ((pad_oe & $past(wb)) == $past(wb)));

    assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == strobe_addr(0, 1'b1)) |=> ((pad_oe & $past(wb)) == '0));

    assert_enable_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0);

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_STATUS) |=> ((status & $past(status)) == $past(status)));

    assert_irq_needs_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

bind gpio_bank gpio_bank_checker #(.LINES(LINES)) u_gpio_bank_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .status    (status_w),
    .rise_en   (rise_w),
    .fall_en   (fall_w),
    .irq       (irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h34, r); check("R1 status", r, 32'h0);
        rd(8'h1C, r); check("R1 rise", r, 32'h0);
        rd(8'h38, r); check("R1 mask", r, 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] r;
        wr(8'h08, 32'h0000_00F0);
        check("R2 R4 dir set", pad_oe, 32'h0000_00F0);
        wr(8'h08, 32'h8000_0001);
        check("R2 dir keep zeros", pad_oe, 32'h8000_00F1);
        wr(8'h0C, 32'h0000_0030);
        check("R3 R4 dir clr", pad_oe, 32'h8000_00C1);
        wr(8'h14, 32'hA5A5_0000);
        check("R2 R4 out set", pad_out, 32'hA5A5_0000);
        wr(8'h18, 32'h0505_0000);
        check("R3 R4 out clr", pad_out, 32'hA0A0_0000);
        rd(8'h04, r); check("R4 dir view", r, 32'h8000_00C1);
        rd(8'h08, r); check("R13 set addr reads 0", r, 32'h0);
        rd(8'h18, r); check("R13 clr addr reads 0", r, 32'h0);
        rd(8'h7C, r); check("R13 unmapped reads 0", r, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        bus_addr = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R5 one edge old", bus_rdata, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R5 two edges new", bus_rdata, 32'h1234_5678);
        pads(32'h0);
        rd(8'h00, r); check("R5 back low", r, 32'h0);
    endtask

    task automatic t_edges;
        logic [31:0] r;
        wr(8'h20, 32'h0000_0005);  // rise on 0,2
        wr(8'h2C, 32'h0000_000C);  // fall on 2,3
        pads(32'h0000_001F);
        rd(8'h34, r); check("R6 R8 R9 rise", r, 32'h0000_0005);
        pads(32'h0);
        rd(8'h34, r); check("R7 R8 R9 fall", r, 32'h0000_000D);
        check("R12 unmasked irq low", {31'h0, irq}, 32'h0);
        wr(8'h3C, 32'h0000_0008);
        check("R12 masked irq high", {31'h0, irq}, 32'h1);
        wr(8'h40, 32'h0000_0008);
        check("R12 irq off", {31'h0, irq}, 32'h0);
        rd(8'h34, r); check("R12 status kept", r, 32'h0000_000D);
        wr(8'h34, 32'h0);
        rd(8'h34, r); check("R10 zero write keeps", r, 32'h0000_000D);
        wr(8'h34, 32'h0000_0004);
        rd(8'h34, r); check("R10 exact clear", r, 32'h0000_0009);
        wr(8'h34, 32'h0000_0009);
        rd(8'h34, r); check("R10 all clear", r, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] r;
        // line 0: rise enabled only; make it pending, then clear on the event cycle
        pads(32'h0000_0001);
        rd(8'h34, r); check("R6 pending", r, 32'h1);
        pads(32'h0);
        @(negedge clk);
        pad_in = 32'h0000_0001;
        @(posedge clk); @(posedge clk);
        wr(8'h34, 32'h0000_0001);
        rd(8'h34, r); check("R11 edge beats clear", r, 32'h1);
        wr(8'h34, 32'h0000_0001);
        rd(8'h34, r); check("R11 later clear works", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_level();
        t_edges();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule